// File: doc/BRIEF.md
# Bordered Display Timing Generator

This block produces the output raster timing for a scaler's display side, one count per pixel clock. A horizontal and a vertical counter walk each line and frame in four phases: sync first, then back porch, then the bordered region, then front porch. Four signals come from the counters: a horizontal sync, a vertical sync, a border window covering the whole bordered region, and an active-video window set inside the border by four separately programmed border widths.

The output frame is locked to an incoming frame. After an input frame-start pulse, the block tracks the input position in lines and pixels. When that position reaches a programmed offset (line, pixel), the output counters restart at the first sync count. Between restarts the output raster runs on its own and wraps at its programmed totals. Geometry settings are held in a shadow copy and change only at an output frame start, so a frame is never built from mixed settings. The sync polarity bits and the enable act at once. With the enable low, every output sits at its inactive level.

Top module: `bdr_timing_gen`

## Requirements
- R1: The horizontal count runs 0 to htotal−1, where htotal = sync + back porch + active + front porch. At the end of each line the vertical count steps. It wraps at vtotal−1, where vtotal is formed the same way from the vertical settings.
- R2: On each axis the sync is asserted for counts in [0, sync length). When an axis's polarity bit is 1 its sync pin is high while asserted and low otherwise. When the bit is 0 the pin levels are reversed. Polarity bits take effect immediately.
- R3: On each axis the border window covers counts in [sync + back porch, sync + back porch + active). border_o is high only where both axes lie in their windows.
- R4: The active window covers [border start + low-side border, border end − high-side border) on each axis. Left and top are the low sides; right and bottom are the high sides. active_o is high only where both axes lie in their windows, so it is always inside border_o.
- R5: A frame-start pulse sampled at clock edge E marks input position (line 0, pixel 0) in the cycle after E. The input pixel count wraps at the programmed input line length. When the position equals (vst, hst) for the first time after the pulse, the output counters are both 0 from the next clock edge.
- R6: Changes to the sync, porch, active and border settings take effect only when the output counters return to (0,0), either at the frame wrap or at a restart. Until then the current frame keeps the settings it started with.
- R7: While the enable is 0 the outputs are held inactive: each sync pin is at its inactive level, and border_o and active_o are low. The counters are held at 0 and the settings are loaded into the shadow copy. The first clock edge with the enable at 1 moves the horizontal count to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; 0 holds all outputs inactive |
| hs_pol_i | input | 1 | 1: hsync active high |
| vs_pol_i | input | 1 | 1: vsync active high |
| h_sync_len_i | input | 12 | Horizontal sync length |
| h_bp_i | input | 12 | Horizontal back porch |
| h_act_i | input | 12 | Horizontal bordered width |
| h_fp_i | input | 12 | Horizontal front porch |
| h_bor_lo_i | input | 12 | Left border width |
| h_bor_hi_i | input | 12 | Right border width |
| v_sync_len_i | input | 12 | Vertical sync length in lines |
| v_bp_i | input | 12 | Vertical back porch |
| v_act_i | input | 12 | Vertical bordered height |
| v_fp_i | input | 12 | Vertical front porch |
| v_bor_lo_i | input | 12 | Top border height |
| v_bor_hi_i | input | 12 | Bottom border height |
| in_frame_start_i | input | 1 | Input frame-start pulse |
| in_htotal_i | input | 12 | Input line length in pixels |
| frm_vst_i | input | 12 | Input line at which the output frame restarts |
| frm_hst_i | input | 12 | Input pixel at which the output frame restarts |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| border_o | output | 1 | Border window |
| active_o | output | 1 | Active video window |

## Verification
Some properties are checked on every cycle by assertions. The horizontal count stays below its total. The counters are 0 after a restart and while disabled. The shadow settings stay fixed whenever the line is past its first pixel. Active video never appears outside the border window. The exact placement of sync edges and of the border and active windows under each polarity is shown only by the bench scenarios. The same holds for the cycle on which a restart lands for a given input offset, and for a mid-frame settings change that must wait for the next frame. In those scenarios an independent raster model is compared with the pins on every cycle.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

    localparam int unsigned CW = 12;
    localparam int unsigned NAXIS = 2;
    localparam int unsigned AX_H = 0;
    localparam int unsigned AX_V = 1;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t sync_len;
        cnt_t bp;
        cnt_t act;
        cnt_t fp;
        cnt_t bor_lo;
        cnt_t bor_hi;
    } axis_cfg_t;

    typedef struct packed {
        logic sync;
        logic border;
        logic active;
    } axis_flags_t;

    function automatic cnt_t axis_total(axis_cfg_t c);
        return c.sync_len + c.bp + c.act + c.fp;
    endfunction

    function automatic cnt_t axis_bor_start(axis_cfg_t c);
        return c.sync_len + c.bp;
    endfunction

endpackage

// File: rtl/bdr_axis_decode.sv
module bdr_axis_decode
    import bdr_pkg::*;
(
    input  cnt_t        cnt_i,
    input  axis_cfg_t   cfg_i,
    output axis_flags_t flags_o
);

    cnt_t bor_st;
    cnt_t bor_end;
    cnt_t act_st;
    cnt_t act_end;

    always_comb begin
        bor_st  = axis_bor_start(cfg_i);
        bor_end = bor_st + cfg_i.act;
        act_st  = bor_st + cfg_i.bor_lo;
        act_end = bor_end - cfg_i.bor_hi;
        flags_o.sync   = (cnt_i < cfg_i.sync_len);
        flags_o.border = (cnt_i >= bor_st) && (cnt_i < bor_end);
        flags_o.active = (cnt_i >= act_st) && (cnt_i < act_end);
    end

endmodule

// File: rtl/bdr_in_tracker.sv
module bdr_in_tracker
    import bdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_start_i,
    input  cnt_t htotal_i,
    input  cnt_t vst_i,
    input  cnt_t hst_i,
    output logic restart_o
);

    cnt_t pix_q;
    cnt_t line_q;
    logic armed_q;
    logic hit;

    assign hit       = armed_q && !frame_start_i && (pix_q == hst_i) && (line_q == vst_i);
    assign restart_o = hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q   <= '0;
            line_q  <= '0;
            armed_q <= 1'b0;
        end else if (frame_start_i) begin
            pix_q   <= '0;
            line_q  <= '0;
            armed_q <= 1'b1;
        end else begin
            if (hit) begin
                armed_q <= 1'b0;
            end
            if (pix_q == htotal_i - 1'b1) begin
                pix_q  <= '0;
                line_q <= line_q + 1'b1;
            end else begin
                pix_q <= pix_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bdr_frame_counter.sv
module bdr_frame_counter
    import bdr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      restart_i,
    input  axis_cfg_t cfg_h_i,
    input  axis_cfg_t cfg_v_i,
    output cnt_t      h_cnt_o,
    output cnt_t      v_cnt_o,
    output axis_cfg_t sh_h_o,
    output axis_cfg_t sh_v_o
);

    cnt_t      h_q;
    cnt_t      v_q;
    axis_cfg_t sh_h_q;
    axis_cfg_t sh_v_q;
    cnt_t      htot;
    cnt_t      vtot;
    logic      h_last;
    logic      v_last;

    assign htot   = axis_total(sh_h_q);
    assign vtot   = axis_total(sh_v_q);
    assign h_last = (h_q == htot - 1'b1);
    assign v_last = (v_q == vtot - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q    <= '0;
            v_q    <= '0;
            sh_h_q <= '0;
            sh_v_q <= '0;
        end else if (!en_i || restart_i) begin
            h_q    <= '0;
            v_q    <= '0;
            sh_h_q <= cfg_h_i;
            sh_v_q <= cfg_v_i;
        end else if (h_last) begin
            h_q <= '0;
            if (v_last) begin
                v_q    <= '0;
                sh_h_q <= cfg_h_i;
                sh_v_q <= cfg_v_i;
            end else begin
                v_q <= v_q + 1'b1;
            end
        end else begin
            h_q <= h_q + 1'b1;
        end
    end

    assign h_cnt_o = h_q;
    assign v_cnt_o = v_q;
    assign sh_h_o  = sh_h_q;
    assign sh_v_o  = sh_v_q;

    AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (htot != '0) |-> (h_q < htot)); // R1

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (en_i && restart_i) |=> (h_q == '0 && v_q == '0)); // R5

    AST_DIS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (h_q == '0 && v_q == '0)); // R7

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (h_q != '0) |-> ($stable(sh_h_q) && $stable(sh_v_q))); // R6

endmodule

// File: rtl/bdr_timing_gen.sv
module bdr_timing_gen
    import bdr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          hs_pol_i,
    input  logic          vs_pol_i,
    input  logic [CW-1:0] h_sync_len_i,
    input  logic [CW-1:0] h_bp_i,
    input  logic [CW-1:0] h_act_i,
    input  logic [CW-1:0] h_fp_i,
    input  logic [CW-1:0] h_bor_lo_i,
    input  logic [CW-1:0] h_bor_hi_i,
    input  logic [CW-1:0] v_sync_len_i,
    input  logic [CW-1:0] v_bp_i,
    input  logic [CW-1:0] v_act_i,
    input  logic [CW-1:0] v_fp_i,
    input  logic [CW-1:0] v_bor_lo_i,
    input  logic [CW-1:0] v_bor_hi_i,
    input  logic          in_frame_start_i,
    input  logic [CW-1:0] in_htotal_i,
    input  logic [CW-1:0] frm_vst_i,
    input  logic [CW-1:0] frm_hst_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          border_o,
    output logic          active_o
);

    axis_cfg_t   live_cfg [NAXIS];
    axis_cfg_t   sh_cfg   [NAXIS];
    cnt_t        cnt      [NAXIS];
    axis_flags_t flags    [NAXIS];
    logic        restart;

    assign live_cfg[AX_H] = '{sync_len: h_sync_len_i, bp: h_bp_i, act: h_act_i,
                              fp: h_fp_i, bor_lo: h_bor_lo_i, bor_hi: h_bor_hi_i};
    assign live_cfg[AX_V] = '{sync_len: v_sync_len_i, bp: v_bp_i, act: v_act_i,
                              fp: v_fp_i, bor_lo: v_bor_lo_i, bor_hi: v_bor_hi_i};

    bdr_in_tracker u_track (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (in_frame_start_i),
        .htotal_i      (in_htotal_i),
        .vst_i         (frm_vst_i),
        .hst_i         (frm_hst_i),
        .restart_o     (restart)
    );

    bdr_frame_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .restart_i (restart),
        .cfg_h_i   (live_cfg[AX_H]),
        .cfg_v_i   (live_cfg[AX_V]),
        .h_cnt_o   (cnt[AX_H]),
        .v_cnt_o   (cnt[AX_V]),
        .sh_h_o    (sh_cfg[AX_H]),
        .sh_v_o    (sh_cfg[AX_V])
    );

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        bdr_axis_decode u_dec (
            .cnt_i   (cnt[a]),
            .cfg_i   (sh_cfg[a]),
            .flags_o (flags[a])
        );
    end

    logic hs_act;
    logic vs_act;

    assign hs_act   = en_i && flags[AX_H].sync;
    assign vs_act   = en_i && flags[AX_V].sync;
    assign hsync_o  = hs_pol_i ? hs_act : !hs_act;
    assign vsync_o  = vs_pol_i ? vs_act : !vs_act;
    assign border_o = en_i && flags[AX_H].border && flags[AX_V].border;
    assign active_o = en_i && flags[AX_H].active && flags[AX_V].active;

    AST_ACT_IN_BORDER: assert property (@(posedge clk) disable iff (rst)
        active_o |-> border_o); // R4

endmodule

// File: tb/bdr_timing_gen_tb_top.sv
`timescale 1ns/1ps
module bdr_timing_gen_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic hs_pol = 1'b1;
    logic vs_pol = 1'b0;
    logic [11:0] hc [6];
    logic [11:0] vc [6];
    logic in_fs = 1'b0;
    logic [11:0] in_ht = 12'd7;
    logic [11:0] vst = 12'd1;
    logic [11:0] hst = 12'd3;
    logic hsync, vsync, border, active;

    always #2.5 clk = ~clk;

    bdr_timing_gen dut_i (
        .clk(clk), .rst(rst), .en_i(en), .hs_pol_i(hs_pol), .vs_pol_i(vs_pol),
        .h_sync_len_i(hc[0]), .h_bp_i(hc[1]), .h_act_i(hc[2]), .h_fp_i(hc[3]),
        .h_bor_lo_i(hc[4]), .h_bor_hi_i(hc[5]),
        .v_sync_len_i(vc[0]), .v_bp_i(vc[1]), .v_act_i(vc[2]), .v_fp_i(vc[3]),
        .v_bor_lo_i(vc[4]), .v_bor_hi_i(vc[5]),
        .in_frame_start_i(in_fs), .in_htotal_i(in_ht),
        .frm_vst_i(vst), .frm_hst_i(hst),
        .hsync_o(hsync), .vsync_o(vsync), .border_o(border), .active_o(active)
    );

    int n_chk = 0;
    int n_fail = 0;
    int ex_h = 0;
    int ex_v = 0;
    int hs_sh [6];
    int vs_sh [6];
    int rs_cnt = 0;
    int bor_seen = 0;
    bit done = 0;

    task automatic chk(string tag, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b (h=%0d v=%0d)", tag, what, got, exp, ex_h, ex_v);
        end
    endtask

    task automatic load_shadow();
        for (int i = 0; i < 6; i++) begin
            hs_sh[i] = int'(hc[i]);
            vs_sh[i] = int'(vc[i]);
        end
    endtask

    function automatic int tot(int s[6]);
        return s[0] + s[1] + s[2] + s[3];
    endfunction

    function automatic bit in_bor(int c, int s[6]);
        return (c >= s[0] + s[1]) && (c < s[0] + s[1] + s[2]);
    endfunction

    function automatic bit in_act(int c, int s[6]);
        return (c >= s[0] + s[1] + s[4]) && (c < s[0] + s[1] + s[2] - s[5]);
    endfunction

    task automatic check_now(string tag);
        bit ha, va;
        ha = en && (ex_h < hs_sh[0]);
        va = en && (ex_v < vs_sh[0]);
        chk(tag, "hsync", hsync, hs_pol ? ha : !ha);
        chk(tag, "vsync", vsync, vs_pol ? va : !va);
        chk(tag, "border", border, en && in_bor(ex_h, hs_sh) && in_bor(ex_v, vs_sh));
        chk(tag, "active", active, en && in_act(ex_h, hs_sh) && in_act(ex_v, vs_sh));
        if (border === 1'b1) bor_seen++;
    endtask

    // one clock: model advances at the edge, outputs compared mid-cycle
    task automatic step(string tag);
        bit do_rs;
        @(posedge clk);
        do_rs = 0;
        if (rs_cnt > 0) begin
            rs_cnt--;
            if (rs_cnt == 0) do_rs = 1;
        end
        if (!en || do_rs) begin
            ex_h = 0; ex_v = 0; load_shadow();
        end else if (ex_h == tot(hs_sh) - 1) begin
            ex_h = 0;
            if (ex_v == tot(vs_sh) - 1) begin
                ex_v = 0; load_shadow();
            end else ex_v++;
        end else ex_h++;
        @(negedge clk);
        #1;
        check_now(tag);
        in_fs = 1'b0;
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R7", "hsync in reset", hsync, 1'b0);
        chk("R7", "vsync in reset", vsync, 1'b1);
        chk("R7", "border in reset", border, 1'b0);
        chk("R7", "active in reset", active, 1'b0);
        rst = 1'b0;
        run("R7", 3);
    endtask

    task automatic t_free_run();
        en = 1'b1;
        bor_seen = 0;
        run("R3", 400);
        // two full 200-cycle frames, 10x5 border each
        n_chk++;
        if (bor_seen != 100) begin
            n_fail++;
            $display("FAIL R1 border cycles over two frames: got %0d expected %0d", bor_seen, 100);
        end
    endtask

    task automatic t_polarity();
        hs_pol = 1'b0; vs_pol = 1'b1;
        run("R2", 250);
        hs_pol = 1'b1; vs_pol = 1'b1;
        run("R2", 60);
    endtask

    task automatic t_shadow();
        run("R6", 37);
        hc[0] = 12'd5;
        hc[2] = 12'd12;
        vc[4] = 12'd2;
        run("R6", 500);
    endtask

    task automatic t_restart();
        in_fs = 1'b1;
        rs_cnt = 1 + int'(vst) * int'(in_ht) + int'(hst) + 1;
        run("R5", 120);
        vst = 12'd0; hst = 12'd0;
        in_fs = 1'b1;
        rs_cnt = 2;
        run("R5", 40);
    endtask

    task automatic t_disable();
        en = 1'b0;
        hc[5] = 12'd3;
        run("R7", 10);
        en = 1'b1;
        run("R4", 260);
    endtask

    initial begin
        hc[0] = 12'd4; hc[1] = 12'd3; hc[2] = 12'd10; hc[3] = 12'd3; hc[4] = 12'd2; hc[5] = 12'd1;
        vc[0] = 12'd2; vc[1] = 12'd2; vc[2] = 12'd5;  vc[3] = 12'd1; vc[4] = 12'd1; vc[5] = 12'd1;
        load_shadow();
        repeat (3) @(posedge clk);
        t_reset();
        t_free_run();
        t_polarity();
        t_shadow();
        t_restart();
        t_disable();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired: got hung run expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule